// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block is the 32-bit control and status word of a real-time clock. Software reaches it through a plain synchronous port: a write strobe with a data word, and a read word that always shows the current contents. The word holds a self-reset bit, a master run enable, a fast-timer enable, two deep power-down wake masks, two oscillator storage bits, a sub-second enable and two sticky event flags.

Two external sources deliver single-cycle event pulses. One is the once-per-second alarm comparator and the other is the millisecond wake-up timer. Each pulse sets its sticky flag. The flags drive the interrupt requests, and through the masks they also drive the deep power-down wake request. The block also turns a reference tick into the once-per-second count pulse. It delays that pulse by one full second after the master enable is set. It also drives the gated enables for the millisecond timer and for the sub-second counter.

The block leaves self-reset only when a write clears the self-reset bit. Each later configuration needs a separate write after that one.

Top module: `rtc_ctl_reg`

## Requirements
- R1: After the asynchronous reset the read word is 0x00000001. Every output is 0.
- R2: While bit 0 (self-reset) is 1, every other bit stays 0. A write with bit 0 = 1 has no effect. A write with bit 0 = 0 clears only bit 0, and the other data bits of that write are ignored. Event pulses are ignored.
- R3: If bit 0 is 0 and a write sets bit 0, the next read word is 0x00000001.
- R4: Bit 2 (alarm flag) and bit 3 (wake flag) are set by their event inputs. Writing 1 to a flag clears it. Writing 0 to a flag leaves it unchanged.
- R5: If an event pulse and a write-1-to-clear reach the same flag in the same cycle, the flag is 1 afterwards.
- R6: alarm_irq_o equals bit 2 and wake_irq_o equals bit 3. dpd_wake_o is (bit 2 AND bit 4) OR (bit 3 AND bit 5).
- R7: Bit 7 is the master enable and bit 6 is the millisecond enable. khz_en_o is bit 6 AND bit 7.
- R8: A write can set bit 10 (sub-second enable) only if bit 7 was already 1 before that write and the write keeps bit 7 at 1. Bit 10 is 0 whenever bit 7 is 0.
- R9: While bit 7 is 1, every SEC_TICKS-th ref_tick_i pulse produces sec_pulse_o in the same cycle. The count starts at 0 when bit 7 is set, so the first pulse comes one full second after enable. While bit 7 is 0 there is no sec_pulse_o.
- R10: subsec_en_o rises in the cycle after the first sec_pulse_o that occurs while bit 10 is 1. It falls in the cycle after bit 10 reads 0.
- R11: Bits 8 and 9 are plain read/write storage bits. They drive osc_pd_o and osc_bypass_o.
- R12: Bit 1 and bits 11 to 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register contents |
| ref_tick_i | input | 1 | Reference tick, SEC_TICKS per second |
| alarm_evt_i | input | 1 | One-cycle alarm comparator event |
| wake_evt_i | input | 1 | One-cycle millisecond timer event |
| alarm_irq_o | output | 1 | Alarm interrupt request |
| wake_irq_o | output | 1 | Wake interrupt request |
| dpd_wake_o | output | 1 | Deep power-down wake request |
| sec_pulse_o | output | 1 | Once-per-second count pulse |
| khz_en_o | output | 1 | Gated millisecond timer enable |
| subsec_en_o | output | 1 | Gated sub-second counter enable |
| osc_pd_o | output | 1 | Oscillator power-down storage bit |
| osc_bypass_o | output | 1 | Oscillator bypass storage bit |

## Verification
Almost all internal state is visible on rd_data_o in the cycle after it changes. A wrong flag, mask or enable therefore appears at the ports one clock after the faulty update, either in the read word or in the interrupt and wake outputs. The two exceptions are the prescaler count and the sub-second arming state, which are hidden. A wrong count shows only as a misplaced sec_pulse_o, which can come up to SEC_TICKS reference ticks late. A wrong arming state shows as a subsec_en_o edge that is off by one or more seconds.

// File: rtl/rtc_ctl_pkg.sv
`timescale 1ns/1ps
package rtc_ctl_pkg;

  localparam int REG_W = 32;

  // Bit positions of the control word (software decodes these)
  localparam int B_SWRST     = 0;
  localparam int B_ALARM     = 2;
  localparam int B_WAKE      = 3;
  localparam int B_ALARM_DPD = 4;
  localparam int B_WAKE_DPD  = 5;
  localparam int B_KHZ       = 6;
  localparam int B_MASTER    = 7;
  localparam int B_OSC_PD    = 8;
  localparam int B_OSC_BYP   = 9;
  localparam int B_SUBSEC    = 10;

  localparam int N_FLAGS = 2;
  localparam int FLAG_ALARM = 0;
  localparam int FLAG_WAKE  = 1;

  localparam logic [REG_W-1:0] RESET_WORD = REG_W'(1);

  typedef struct packed {
    logic osc_byp;
    logic osc_pd;
    logic master;
    logic khz;
    logic wake_dpd;
    logic alarm_dpd;
  } cfg_t;

endpackage

// File: rtl/rtc_ctl_flag.sv
`timescale 1ns/1ps
// Sticky event flag: the event has priority over the clear, and hold forces the flag to 0
module rtc_ctl_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_en;

  always_comb begin
    if (hold_i)      flag_d = 1'b0;
    else if (set_i)  flag_d = 1'b1;
    else if (clr_i)  flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  assign flag_en = hold_i | set_i | clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/rtc_ctl_sec_presc.sv
`timescale 1ns/1ps
// Divides the reference tick down to the once-per-second pulse and arms the sub-second enable
module rtc_ctl_sec_presc #(
  parameter int SEC_TICKS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic sub_arm_i,
  output logic sec_pulse_o,
  output logic sub_run_o
);

  localparam int CNT_W = (SEC_TICKS > 2) ? $clog2(SEC_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEC_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             sub_q, sub_d, sub_en;
  logic             at_last;

  assign at_last     = (cnt_q == LAST);
  assign sec_pulse_o = run_i & tick_i & at_last;

  // The count restarts from zero whenever the master enable is low
  always_comb begin
    if (!run_i)       cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end
  assign cnt_en = tick_i | ~run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    if (!sub_arm_i)       sub_d = 1'b0;
    else if (sec_pulse_o) sub_d = 1'b1;
    else                  sub_d = sub_q;
  end
  assign sub_en = ~sub_arm_i | sec_pulse_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sub_q <= 1'b0;
    else if (sub_en) sub_q <= sub_d;
  end

  assign sub_run_o = sub_q;

endmodule

// File: rtl/rtc_ctl_reg.sv
`timescale 1ns/1ps
module rtc_ctl_reg
  import rtc_ctl_pkg::*;
#(
  parameter int SEC_TICKS = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        ref_tick_i,
  input  logic        alarm_evt_i,
  input  logic        wake_evt_i,
  output logic        alarm_irq_o,
  output logic        wake_irq_o,
  output logic        dpd_wake_o,
  output logic        sec_pulse_o,
  output logic        khz_en_o,
  output logic        subsec_en_o,
  output logic        osc_pd_o,
  output logic        osc_bypass_o
);

  // Self-reset bit
  logic swrst_q, swrst_d, swrst_en;
  logic enter_rst, cfg_we, hold;

  assign enter_rst = ~swrst_q & wr_en_i &  wr_data_i[B_SWRST];
  assign cfg_we    = ~swrst_q & wr_en_i & ~wr_data_i[B_SWRST];
  assign hold      = swrst_q | enter_rst;

  always_comb begin
    if (swrst_q) swrst_d = ~(wr_en_i & ~wr_data_i[B_SWRST]);
    else         swrst_d = enter_rst;
  end
  assign swrst_en = wr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       swrst_q <= 1'b1;
    else if (swrst_en) swrst_q <= swrst_d;
  end

  // Configuration bits
  cfg_t cfg_q, cfg_d, cfg_wr;
  logic cfg_en;

  always_comb begin
    cfg_wr.osc_byp   = wr_data_i[B_OSC_BYP];
    cfg_wr.osc_pd    = wr_data_i[B_OSC_PD];
    cfg_wr.master    = wr_data_i[B_MASTER];
    cfg_wr.khz       = wr_data_i[B_KHZ];
    cfg_wr.wake_dpd  = wr_data_i[B_WAKE_DPD];
    cfg_wr.alarm_dpd = wr_data_i[B_ALARM_DPD];
  end

  always_comb begin
    if (hold)        cfg_d = '0;
    else if (cfg_we) cfg_d = cfg_wr;
    else             cfg_d = cfg_q;
  end
  assign cfg_en = hold | cfg_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // Sub-second enable: it can be set only on top of an existing master enable
  logic subsec_q, subsec_d, subsec_en;

  always_comb begin
    if (hold)        subsec_d = 1'b0;
    else if (cfg_we) subsec_d = wr_data_i[B_SUBSEC] & wr_data_i[B_MASTER] & cfg_q.master;
    else             subsec_d = subsec_q & cfg_q.master;
  end
  assign subsec_en = hold | cfg_we | ~cfg_q.master;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        subsec_q <= 1'b0;
    else if (subsec_en) subsec_q <= subsec_d;
  end

  // Sticky event flags
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_val;
  localparam int FLAG_BIT [N_FLAGS] = '{B_ALARM, B_WAKE};

  assign flag_set[FLAG_ALARM] = alarm_evt_i;
  assign flag_set[FLAG_WAKE]  = wake_evt_i;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    assign flag_clr[g] = cfg_we & wr_data_i[FLAG_BIT[g]];
    rtc_ctl_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hold_i (hold),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .flag_o (flag_val[g])
    );
  end

  // Second prescaler and sub-second arming
  rtc_ctl_sec_presc #(.SEC_TICKS(SEC_TICKS)) u_presc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (cfg_q.master),
    .tick_i      (ref_tick_i),
    .sub_arm_i   (subsec_q),
    .sec_pulse_o (sec_pulse_o),
    .sub_run_o   (subsec_en_o)
  );

  // Read word
  always_comb begin
    rd_data_o              = '0;
    rd_data_o[B_SWRST]     = swrst_q;
    rd_data_o[B_ALARM]     = flag_val[FLAG_ALARM];
    rd_data_o[B_WAKE]      = flag_val[FLAG_WAKE];
    rd_data_o[B_ALARM_DPD] = cfg_q.alarm_dpd;
    rd_data_o[B_WAKE_DPD]  = cfg_q.wake_dpd;
    rd_data_o[B_KHZ]       = cfg_q.khz;
    rd_data_o[B_MASTER]    = cfg_q.master;
    rd_data_o[B_OSC_PD]    = cfg_q.osc_pd;
    rd_data_o[B_OSC_BYP]   = cfg_q.osc_byp;
    rd_data_o[B_SUBSEC]    = subsec_q;
  end

  // Request and enable outputs
  assign alarm_irq_o  = flag_val[FLAG_ALARM];
  assign wake_irq_o   = flag_val[FLAG_WAKE];
  assign dpd_wake_o   = (flag_val[FLAG_ALARM] & cfg_q.alarm_dpd) |
                        (flag_val[FLAG_WAKE]  & cfg_q.wake_dpd);
  assign khz_en_o     = cfg_q.khz & cfg_q.master;
  assign osc_pd_o     = cfg_q.osc_pd;
  assign osc_bypass_o = cfg_q.osc_byp;

  logic unused_wr;
  assign unused_wr = ^{wr_data_i[31:11], wr_data_i[1]};

endmodule

// File: rtl/rtc_ctl_reg_chk.sv
`timescale 1ns/1ps
module rtc_ctl_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_b0_i,
  input logic        wr_b2_i,
  input logic        alarm_evt_i,
  input logic        ref_tick_i,
  input logic [31:0] rd_data_i,
  input logic        khz_en_i,
  input logic        dpd_wake_i,
  input logic        sec_pulse_i
);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i[0] |-> (rd_data_i[31:1] == 31'd0));

  assert_enter_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_i[0] && wr_en_i && wr_b0_i) |=> (rd_data_i == 32'h1));

  assert_w1c_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i[2] && !rd_data_i[0] && !(wr_en_i && (wr_b0_i || wr_b2_i))) |=> rd_data_i[2]);

  assert_event_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_i[0] && !(wr_en_i && wr_b0_i) && alarm_evt_i) |=> rd_data_i[2]);

  assert_dpd_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_i[4] && !rd_data_i[5]) |-> !dpd_wake_i);

  assert_khz_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_i[7] |-> !khz_en_i);

  assert_subsec_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_i[10]) |-> $past(rd_data_i[7]));

  assert_pulse_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_i |-> (rd_data_i[7] && ref_tick_i));

  assert_reserved_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i[1] == 1'b0) && (rd_data_i[31:11] == 21'd0));

endmodule

bind rtc_ctl_reg rtc_ctl_reg_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_b0_i     (wr_data_i[0]),
  .wr_b2_i     (wr_data_i[2]),
  .alarm_evt_i (alarm_evt_i),
  .ref_tick_i  (ref_tick_i),
  .rd_data_i   (rd_data_o),
  .khz_en_i    (khz_en_o),
  .dpd_wake_i  (dpd_wake_o),
  .sec_pulse_i (sec_pulse_o)
);

// File: tb/rtc_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module rtc_ctl_reg_tb_top;

  localparam int SEC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0, aevt = 1'b0, wevt = 1'b0;
  logic [31:0] rd_data;
  logic        alarm_irq, wake_irq, dpd_wake, sec_pulse, khz_en, subsec_en, osc_pd, osc_byp;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;  // 250 MHz

  rtc_ctl_reg #(.SEC_TICKS(SEC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ref_tick_i(tick), .alarm_evt_i(aevt), .wake_evt_i(wevt),
    .alarm_irq_o(alarm_irq), .wake_irq_o(wake_irq), .dpd_wake_o(dpd_wake),
    .sec_pulse_o(sec_pulse), .khz_en_o(khz_en), .subsec_en_o(subsec_en),
    .osc_pd_o(osc_pd), .osc_bypass_o(osc_byp)
  );

  // Behavioural reference model
  logic [31:0] m_reg;
  int          m_cnt;
  bit          m_run;
  logic [31:0] m_nxt;
  bit          m_pulse;

  function automatic bit exp_pulse();
    return m_reg[7] && tick && (m_cnt == SEC - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 32'h1; m_cnt = 0; m_run = 0;
    end else begin
      m_pulse = exp_pulse();
      m_nxt = m_reg;
      if (m_reg[0]) begin
        if (wr_en && !wr_data[0]) m_nxt = 32'h0;
      end else begin
        if (wr_en) begin
          if (wr_data[0]) m_nxt = 32'h1;
          else begin
            m_nxt[9:4] = wr_data[9:4];
            if (wr_data[2]) m_nxt[2] = 1'b0;
            if (wr_data[3]) m_nxt[3] = 1'b0;
            m_nxt[10] = wr_data[10] && wr_data[7] && m_reg[7];
          end
        end
        if (!m_nxt[0]) begin
          if (aevt) m_nxt[2] = 1'b1;
          if (wevt) m_nxt[3] = 1'b1;
        end
      end
      if (!m_reg[7]) m_cnt = 0;
      else if (tick) m_cnt = (m_cnt == SEC - 1) ? 0 : m_cnt + 1;
      if (!m_reg[10]) m_run = 0;
      else if (m_pulse) m_run = 1;
      m_reg = m_nxt;
    end
  end

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare the design against the model on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      ck("R3 self-reset bit", {31'd0, rd_data[0]}, {31'd0, m_reg[0]});
      ck("R4 flags", {30'd0, rd_data[3:2]}, {30'd0, m_reg[3:2]});
      ck("R7 enables/masks", {28'd0, rd_data[7:4]}, {28'd0, m_reg[7:4]});
      ck("R11 osc bits", {30'd0, rd_data[9:8]}, {30'd0, m_reg[9:8]});
      ck("R8 subsec bit", {31'd0, rd_data[10]}, {31'd0, m_reg[10]});
      ck("R12 reserved", rd_data & 32'hFFFF_F802, 32'h0);
      ck("R6 irqs", {30'd0, wake_irq, alarm_irq}, {30'd0, m_reg[3], m_reg[2]});
      ck("R6 dpd wake", {31'd0, dpd_wake},
         {31'd0, (m_reg[2] & m_reg[4]) | (m_reg[3] & m_reg[5])});
      ck("R7 khz enable", {31'd0, khz_en}, {31'd0, m_reg[6] & m_reg[7]});
      ck("R9 second pulse", {31'd0, sec_pulse}, {31'd0, exp_pulse()});
      ck("R10 subsec enable", {31'd0, subsec_en}, {31'd0, m_run});
      ck("R11 osc outputs", {30'd0, osc_byp, osc_pd}, {30'd0, m_reg[9], m_reg[8]});
    end
  end

  task automatic cyc(input bit w, input logic [31:0] d, input bit t, input bit a, input bit e);
    @(negedge clk); #1;
    wr_en = w; wr_data = d; tick = t; aevt = a; wevt = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 32'h0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  int pulses;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    ck("R1 reset word", rd_data, 32'h1);
    ck("R1 outputs idle", {24'd0, alarm_irq, wake_irq, dpd_wake, sec_pulse, khz_en, subsec_en, osc_pd, osc_byp}, 32'h0);

    // R2: held in self-reset
    cyc(1, 32'hFFFF_FFFF, 1, 1, 1);
    idle(1);
    ck("R2 write with bit0 set ignored", rd_data, 32'h1);
    cyc(1, 32'h0000_07FE, 0, 1, 1);
    idle(1);
    ck("R2 leaving reset ignores other bits", rd_data, 32'h0);

    // R8: bit10 requires an earlier master enable
    cyc(1, 32'h0000_07F0, 0, 0, 0);
    idle(1);
    ck("R8 subsec refused without prior master", rd_data, 32'h0000_03F0);
    ck("R11 osc driven", {30'd0, osc_byp, osc_pd}, 32'h3);
    cyc(1, 32'h0000_04F0, 0, 0, 0);
    idle(1);
    ck("R8 subsec accepted", rd_data, 32'h0000_04F0);

    // R9/R10: run ticks
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(0, 32'h0, (i % 3) == 0, 0, 0);
      if (i == 20) ck("R10 subsec running after a second", {31'd0, subsec_en}, 32'h1);
    end

    // R4/R5/R6: flags
    cyc(0, 32'h0, 0, 1, 0);
    idle(1);
    ck("R4 alarm set", {31'd0, rd_data[2]}, 32'h1);
    ck("R6 dpd from alarm", {31'd0, dpd_wake}, 32'h1);
    cyc(1, 32'h0000_04F0, 0, 0, 0);
    idle(1);
    ck("R4 write 0 keeps flag", {31'd0, rd_data[2]}, 32'h1);
    cyc(1, 32'h0000_04F4, 0, 1, 0);
    idle(1);
    ck("R5 event beats clear", {31'd0, rd_data[2]}, 32'h1);
    cyc(1, 32'h0000_04FC, 0, 0, 0);
    idle(1);
    ck("R4 write 1 clears", {30'd0, rd_data[3:2]}, 32'h0);

    // R8: master off clears bit10
    cyc(1, 32'h0000_0470, 0, 0, 0);
    idle(2);
    ck("R8 subsec cleared with master", {31'd0, rd_data[10]}, 32'h0);
    ck("R7 khz off with master", {31'd0, khz_en}, 32'h0);

    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 24) != 0) d[0] = 1'b0;
      if (($urandom % 3) != 0) d[7] = 1'b1;
      cyc(($urandom % 5) == 0, d, ($urandom % 2) == 0, ($urandom % 9) == 0, ($urandom % 9) == 0);
    end

    // R3: entering self-reset from running
    cyc(1, 32'h0000_00F0, 0, 0, 0);
    cyc(1, 32'h0000_04F1, 0, 0, 0);
    idle(1);
    ck("R3 enter self-reset", rd_data, 32'h1);
    idle(2);
    finish_run();
  end

endmodule